// File: doc/BRIEF.md
# Lockable Memory Carveout Access Checker

This block guards a set of programmable physical-memory windows. Every window has a base address, a length counted in 128 KiB granules, a client permission bitmap and a 32-bit configuration word. Software programs the windows through a one-cycle register-write port. A flag on that port marks writes that come from the secure world.

Each memory request presents an address, a client number, a direction, an access level (0 to 3), a secure flag and a translated flag. The checker answers grant or deny combinationally in the same cycle. A request is denied if any window it falls into rejects it.

The first denied request is held in a sticky error record and raises an interrupt. The record stays until software pulses the clear input. Configuration can be frozen until reset. A protect option still lets the secure world rewrite a frozen window.

Top module: `cvo_checker`

## Requirements
- R1: After reset, every window has length 0, configuration 0 and an empty bitmap. Every request is granted and `err_irq` is low.
- R2: The base of a window is {base-high word bits [ADDR_W-33:0], base-low word}. The window covers addresses from base (inclusive) up to base + length*128 KiB (exclusive). A window of length 0 covers nothing. A request that falls into no window is granted.
- R3: Client number c is permitted by bitmap word c/32, bit c%32. Client numbers at or above 32*WL_WORDS are never permitted. A request inside a window whose bitmap lacks the client is denied unless R5 applies.
- R4: A read at level L passes the level test when configuration bit 3+L or bit 14+L is set. A write at level L passes when bit 7+L or bit 18+L is set. A non-bypassed request needs both the client bit and the level test.
- R5: A secure write is granted by a window whose configuration bit 23 is set. A secure read is granted by a window whose bit 24 is set. Neither the client bitmap nor the level test is consulted in those cases.
- R6: When configuration bit 2 is set, a window only covers requests whose translated flag is 0.
- R7: A request covered by several windows is granted only if every one of them grants it.
- R8: While configuration bit 1 (lock) of a window is 1, writes to any register of that window are ignored. The one exception is when configuration bit 0 (protect) is 1 and the write's secure flag is set.
- R9: A register write takes effect on the next clock edge. The select field decodes as 0 = configuration, 1 = base low, 2 = base high, 3 = length, 4+k = bitmap word k. Writes with an unused select value or a window index at or above NUM_REGIONS are ignored.
- R10: When a request with `req_valid` high is denied and no error is held, the next edge captures its address, client and direction and sets `err_irq`. Later denials leave the record unchanged.
- R11: `err_clear` empties the record on the next edge. A denial in the same cycle as the clear is captured instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_region | input | RIDX_W | Window index of the write |
| cfg_wr_sel | input | 4 | Register select within the window |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_secure | input | 1 | Write issued by the secure world |
| req_valid | input | 1 | Request present (qualifies error capture) |
| req_addr | input | ADDR_W | Physical address of the request |
| req_client | input | CLIENT_W | Client number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Access level 0..3 |
| req_secure | input | 1 | Secure-world request |
| req_translated | input | 1 | Address came through translation |
| req_grant | output | 1 | Combinational grant decision |
| err_clear | input | 1 | Empty the error record |
| err_irq | output | 1 | Error record holds a violation |
| err_addr | output | ADDR_W | Captured address |
| err_client | output | CLIENT_W | Captured client number |
| err_write | output | 1 | Captured direction |

## Verification
The bench uses the default parameters: nine windows, a 40-bit address, a 20-bit length field and five bitmap words. Because the address is wider than 32 bits, bases with a non-zero high word can be tested. With 160 client bits and an 8-bit client number, out-of-range clients 160..255 can be presented. Nine windows leave room for overlapping pairs, a frozen window, a protected window and a bypass window at the same time. A behavioural model mirrors all of them and is compared every cycle, including during a long random request phase.

// File: rtl/cvo_pkg.sv
package cvo_pkg;
    // one granule is 128 KiB
    localparam int GRAN_SHIFT = 17;

    // register select field
    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_CFG     = 4'd0;
    localparam logic [SEL_W-1:0] SEL_BASE_LO = 4'd1;
    localparam logic [SEL_W-1:0] SEL_BASE_HI = 4'd2;
    localparam logic [SEL_W-1:0] SEL_SIZE    = 4'd3;
    localparam logic [SEL_W-1:0] SEL_WL0     = 4'd4;

    // configuration word bit positions
    localparam int CB_PROTECT    = 0;
    localparam int CB_LOCK       = 1;
    localparam int CB_UNTRANS    = 2;
    localparam int CB_RD_LVL     = 3;
    localparam int CB_WR_LVL     = 7;
    localparam int CB_RD_NOCHK   = 14;
    localparam int CB_WR_NOCHK   = 18;
    localparam int CB_SEC_WR_BYP = 23;
    localparam int CB_SEC_RD_BYP = 24;
endpackage

// File: rtl/cvo_region.sv
module cvo_region
    import cvo_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int SIZE_W   = 20,
    parameter int WL_WORDS = 5,
    parameter int CLIENT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [31:0]         wr_data,
    input  logic                wr_secure,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [CLIENT_W-1:0] req_client,
    input  logic                req_write,
    input  logic [1:0]          req_level,
    input  logic                req_secure,
    input  logic                req_translated,
    output logic                hit,
    output logic                allow,
    output logic [31:0]         cfg_o,
    output logic [SIZE_W-1:0]   size_o
);
    localparam int BHI_W    = ADDR_W - 32;
    localparam int WL_BITS  = WL_WORDS * 32;
    localparam int PAD_BITS = 1 << CLIENT_W;
    localparam int SPAN_W   = SIZE_W + GRAN_SHIFT;
    localparam int CMP_W    = ((ADDR_W > SPAN_W) ? ADDR_W : SPAN_W) + 1;

    typedef struct packed {
        logic [31:0]        cfg;
        logic [31:0]        blo;
        logic [BHI_W-1:0]   bhi;
        logic [SIZE_W-1:0]  size;
        logic [WL_BITS-1:0] wl;
    } rg_t;

    rg_t s_d, s_q;
    logic wr_open;

    // next-state: register writes gated by the lock rules
    always_comb begin
        s_d     = s_q;
        wr_open = !s_q.cfg[CB_LOCK] || (s_q.cfg[CB_PROTECT] && wr_secure);
        if (wr_en && wr_open) begin
            case (wr_sel)
                SEL_CFG:     s_d.cfg  = wr_data;
                SEL_BASE_LO: s_d.blo  = wr_data;
                SEL_BASE_HI: s_d.bhi  = wr_data[BHI_W-1:0];
                SEL_SIZE:    s_d.size = wr_data[SIZE_W-1:0];
                default: begin
                    for (int k = 0; k < WL_WORDS; k++) begin
                        if (wr_sel == SEL_W'(int'(SEL_WL0) + k))
                            s_d.wl[k*32 +: 32] = wr_data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // address match
    logic [CMP_W-1:0] base_x, lim_x, addr_x;
    logic             type_ok;
    always_comb begin
        base_x  = CMP_W'({s_q.bhi, s_q.blo});
        lim_x   = base_x + (CMP_W'(s_q.size) << GRAN_SHIFT);
        addr_x  = CMP_W'(req_addr);
        type_ok = !(s_q.cfg[CB_UNTRANS] && req_translated);
        hit     = (s_q.size != '0) && (addr_x >= base_x) && (addr_x < lim_x) && type_ok;
    end

    // permission decision
    logic [PAD_BITS-1:0] wl_pad;
    logic [4:0]          li;
    logic                client_ok, lvl_rd, lvl_wr, bypass;
    always_comb begin
        wl_pad    = PAD_BITS'(s_q.wl);
        client_ok = wl_pad[req_client];
        li        = {3'b000, req_level};
        lvl_rd    = s_q.cfg[5'(CB_RD_LVL) + li] | s_q.cfg[5'(CB_RD_NOCHK) + li];
        lvl_wr    = s_q.cfg[5'(CB_WR_LVL) + li] | s_q.cfg[5'(CB_WR_NOCHK) + li];
        bypass    = req_secure && (req_write ? s_q.cfg[CB_SEC_WR_BYP] : s_q.cfg[CB_SEC_RD_BYP]);
        allow     = bypass || (client_ok && (req_write ? lvl_wr : lvl_rd));
    end

    assign cfg_o  = s_q.cfg;
    assign size_o = s_q.size;
endmodule

// File: rtl/cvo_err_capture.sv
module cvo_err_capture #(
    parameter int ADDR_W   = 40,
    parameter int CLIENT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                violation,
    input  logic [ADDR_W-1:0]   v_addr,
    input  logic [CLIENT_W-1:0] v_client,
    input  logic                v_write,
    input  logic                clear,
    output logic                held,
    output logic [ADDR_W-1:0]   h_addr,
    output logic [CLIENT_W-1:0] h_client,
    output logic                h_write
);
    typedef struct packed {
        logic                valid;
        logic [ADDR_W-1:0]   addr;
        logic [CLIENT_W-1:0] client;
        logic                write;
    } er_t;

    er_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (clear) e_d.valid = 1'b0;
        if (violation && !e_d.valid) begin
            e_d.valid  = 1'b1;
            e_d.addr   = v_addr;
            e_d.client = v_client;
            e_d.write  = v_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign held     = e_q.valid;
    assign h_addr   = e_q.addr;
    assign h_client = e_q.client;
    assign h_write  = e_q.write;
endmodule

// File: rtl/cvo_checker.sv
module cvo_checker
    import cvo_pkg::*;
#(
    parameter int NUM_REGIONS = 9,
    parameter int ADDR_W      = 40,
    parameter int SIZE_W      = 20,
    parameter int WL_WORDS    = 5,
    localparam int CLIENT_W   = $clog2(WL_WORDS * 32),
    localparam int RIDX_W     = $clog2(NUM_REGIONS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [RIDX_W-1:0]   cfg_wr_region,
    input  logic [3:0]          cfg_wr_sel,
    input  logic [31:0]         cfg_wr_data,
    input  logic                cfg_wr_secure,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [CLIENT_W-1:0] req_client,
    input  logic                req_write,
    input  logic [1:0]          req_level,
    input  logic                req_secure,
    input  logic                req_translated,
    output logic                req_grant,
    input  logic                err_clear,
    output logic                err_irq,
    output logic [ADDR_W-1:0]   err_addr,
    output logic [CLIENT_W-1:0] err_client,
    output logic                err_write
);
    logic [NUM_REGIONS-1:0]             rg_hit, rg_allow;
    logic [NUM_REGIONS-1:0][31:0]       rg_cfg;
    logic [NUM_REGIONS-1:0][SIZE_W-1:0] rg_size;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
        logic sel_me;
        assign sel_me = cfg_wr_en && (cfg_wr_region == RIDX_W'(r));
        cvo_region #(
            .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WL_WORDS(WL_WORDS), .CLIENT_W(CLIENT_W)
        ) u_rgn (
            .clk(clk), .rst_n(rst_n),
            .wr_en(sel_me), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data), .wr_secure(cfg_wr_secure),
            .req_addr(req_addr), .req_client(req_client), .req_write(req_write),
            .req_level(req_level), .req_secure(req_secure), .req_translated(req_translated),
            .hit(rg_hit[r]), .allow(rg_allow[r]), .cfg_o(rg_cfg[r]), .size_o(rg_size[r])
        );
    end

    // every covering window must agree
    always_comb begin
        req_grant = 1'b1;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (rg_hit[r] && !rg_allow[r]) req_grant = 1'b0;
        end
    end

    logic violation;
    assign violation = req_valid && !req_grant;

    cvo_err_capture #(.ADDR_W(ADDR_W), .CLIENT_W(CLIENT_W)) u_err (
        .clk(clk), .rst_n(rst_n), .violation(violation),
        .v_addr(req_addr), .v_client(req_client), .v_write(req_write),
        .clear(err_clear), .held(err_irq), .h_addr(err_addr),
        .h_client(err_client), .h_write(err_write)
    );
endmodule

// File: rtl/cvo_checker_sva.sv
module cvo_checker_sva
    import cvo_pkg::*;
#(
    parameter int NUM_REGIONS = 9,
    parameter int ADDR_W      = 40,
    parameter int SIZE_W      = 20,
    parameter int CLIENT_W    = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_valid,
    input logic [ADDR_W-1:0]                req_addr,
    input logic [CLIENT_W-1:0]              req_client,
    input logic                             req_grant,
    input logic                             err_clear,
    input logic                             err_irq,
    input logic [ADDR_W-1:0]                err_addr,
    input logic [CLIENT_W-1:0]              err_client,
    input logic                             err_write,
    input logic [NUM_REGIONS-1:0]           rg_hit,
    input logic [NUM_REGIONS-1:0]           rg_allow,
    input logic [NUM_REGIONS-1:0][31:0]     rg_cfg,
    input logic [NUM_REGIONS-1:0][SIZE_W-1:0] rg_size
);
    AST_MISS_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_hit == '0) |-> req_grant); // R2

    AST_DENY_HAS_CULPRIT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_grant |-> ((rg_hit & ~rg_allow) != '0)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && !err_clear) |=> (err_irq && $stable(err_addr) && $stable(err_client) && $stable(err_write))); // R10

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_irq && !(req_valid && !req_grant)) |=> !err_irq); // R10

    AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_grant && (!err_irq || err_clear)) |=>
        (err_irq && err_addr == $past(req_addr) && err_client == $past(req_client))); // R11

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !(req_valid && !req_grant)) |=> !err_irq); // R11

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_lock
        AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
            (rg_cfg[r][CB_LOCK] && !rg_cfg[r][CB_PROTECT]) |=> ($stable(rg_cfg[r]) && $stable(rg_size[r]))); // R8
    end
endmodule

bind cvo_checker cvo_checker_sva #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CLIENT_W(CLIENT_W)
) u_sva (.*);

// File: tb/cvo_checker_bench.sv
module cvo_checker_bench;
    localparam int CLK_P = 10;
    localparam int NR    = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 0;
    logic [3:0]  cfg_wr_region = 0;
    logic [3:0]  cfg_wr_sel = 0;
    logic [31:0] cfg_wr_data = 0;
    logic        cfg_wr_secure = 0;
    logic        req_valid = 0;
    logic [39:0] req_addr = 0;
    logic [7:0]  req_client = 0;
    logic        req_write = 0;
    logic [1:0]  req_level = 0;
    logic        req_secure = 0;
    logic        req_translated = 0;
    logic        req_grant;
    logic        err_clear = 0;
    logic        err_irq;
    logic [39:0] err_addr;
    logic [7:0]  err_client;
    logic        err_write;

    always #(CLK_P/2) clk = ~clk;

    cvo_checker u_cvo_checker (.*);

    // behavioural reference
    bit [31:0]      m_cfg [NR];
    bit [31:0]      m_blo [NR];
    bit [7:0]       m_bhi [NR];
    bit [19:0]      m_size[NR];
    bit [4:0][31:0] m_wl  [NR];
    bit             m_ev;
    bit [39:0]      m_ea;
    bit [7:0]       m_ec;
    bit             m_ew;

    int    vectors = 0;
    int    miscompares = 0;
    string tag = "R1";

    function automatic bit m_grant();
        bit g = 1;
        for (int r = 0; r < NR; r++) begin
            longint unsigned base = {24'd0, m_bhi[r], m_blo[r]};
            longint unsigned lim  = base + (longint'(m_size[r]) << 17);
            longint unsigned a    = {24'd0, req_addr};
            if (m_size[r] != 0 && a >= base && a < lim && !(m_cfg[r][2] && req_translated)) begin
                bit ok;
                int lv = req_level;
                if (req_secure && (req_write ? m_cfg[r][23] : m_cfg[r][24])) ok = 1;
                else begin
                    bit cl = (req_client < 160) ? m_wl[r][req_client/32][req_client%32] : 0;
                    bit lt = req_write ? (m_cfg[r][7+lv] | m_cfg[r][18+lv])
                                       : (m_cfg[r][3+lv] | m_cfg[r][14+lv]);
                    ok = cl && lt;
                end
                if (!ok) g = 0;
            end
        end
        return g;
    endfunction

    task automatic compare();
        bit eg = m_grant();
        vectors++;
        if (req_grant !== eg) begin
            miscompares++;
            $display("FAIL %s grant addr=%h client=%0d: got %b exp %b", tag, req_addr, req_client, req_grant, eg);
        end
        if (err_irq !== m_ev) begin
            miscompares++;
            $display("FAIL %s err_irq: got %b exp %b", tag, err_irq, m_ev);
        end else if (m_ev && (err_addr !== m_ea || err_client !== m_ec || err_write !== m_ew)) begin
            miscompares++;
            $display("FAIL %s err record: got %h/%0d/%b exp %h/%0d/%b", tag,
                     err_addr, err_client, err_write, m_ea, m_ec, m_ew);
        end
    endtask

    task automatic model_edge();
        bit viol = req_valid && !m_grant();
        if (cfg_wr_en && cfg_wr_region < NR) begin
            int r = cfg_wr_region;
            if (!m_cfg[r][1] || (m_cfg[r][0] && cfg_wr_secure)) begin
                if (cfg_wr_sel == 0) m_cfg[r] = cfg_wr_data;
                else if (cfg_wr_sel == 1) m_blo[r] = cfg_wr_data;
                else if (cfg_wr_sel == 2) m_bhi[r] = cfg_wr_data[7:0];
                else if (cfg_wr_sel == 3) m_size[r] = cfg_wr_data[19:0];
                else if (cfg_wr_sel <= 8) m_wl[r][cfg_wr_sel-4] = cfg_wr_data;
            end
        end
        if (err_clear) m_ev = 0;
        if (viol && !m_ev) begin
            m_ev = 1; m_ea = req_addr; m_ec = req_client; m_ew = req_write;
        end
    endtask

    task automatic tick();
        #(CLK_P/4);
        compare();
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
    endtask

    task automatic wr(input int r, input int sel, input bit [31:0] d, input bit sec);
        cfg_wr_en = 1; cfg_wr_region = 4'(r); cfg_wr_sel = 4'(sel);
        cfg_wr_data = d; cfg_wr_secure = sec;
        tick();
        cfg_wr_en = 0; cfg_wr_secure = 0;
    endtask

    task automatic rq(input bit [39:0] a, input int c, input bit w, input int lv,
                      input bit sec, input bit tr);
        req_valid = 1; req_addr = a; req_client = 8'(c); req_write = w;
        req_level = 2'(lv); req_secure = sec; req_translated = tr;
        tick();
        req_valid = 0;
    endtask

    initial begin
        #(CLK_P * 100000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        rq(40'h1_0000_0000, 5, 0, 0, 0, 0);
        rst_n = 1;
        rq(40'h1_0000_0000, 5, 1, 3, 0, 0);
        rq(40'h0, 200, 0, 0, 0, 1);

        // window 0: base 0x1_0000_0000, two granules, client 5, level 0 both ways
        tag = "R9";
        wr(0, 2, 32'h1, 0);
        wr(0, 1, 32'h0, 0);
        wr(0, 4, 32'h20, 0);
        wr(0, 0, 32'h88, 0);
        rq(40'h1_0000_0000, 6, 0, 0, 0, 0); // size still 0: covers nothing
        wr(0, 3, 32'h2, 0);
        wr(12, 3, 32'h0, 0);                // bad window index
        wr(0, 15, 32'hFFFF_FFFF, 0);        // bad select
        tag = "R2";
        rq(40'h1_0000_0000, 5, 0, 0, 0, 0);
        rq(40'h1_0003_FFFF, 5, 1, 0, 0, 0);
        rq(40'h1_0004_0000, 6, 0, 0, 0, 0);
        rq(40'h0_FFFF_FFFF, 6, 0, 0, 0, 0);
        tag = "R3";
        rq(40'h1_0001_0000, 6, 0, 0, 0, 0);
        rq(40'h1_0001_0000, 165, 0, 0, 0, 0);
        tag = "R10";
        rq(40'h1_0001_0040, 7, 1, 0, 0, 0);
        tag = "R11";
        err_clear = 1; tick(); err_clear = 0;
        tick();
        err_clear = 1; rq(40'h1_0000_0100, 9, 1, 0, 0, 0); err_clear = 0;
        err_clear = 1; tick(); err_clear = 0;
        tag = "R4";
        rq(40'h1_0000_0000, 5, 0, 1, 0, 0);
        wr(0, 0, 32'h88 | (32'h1 << 15), 0);
        rq(40'h1_0000_0000, 5, 0, 1, 0, 0);
        rq(40'h1_0000_0000, 5, 1, 3, 0, 0);
        rq(40'h1_0000_0000, 5, 1, 1, 0, 0);
        wr(0, 0, 32'h88 | (32'h1 << 15) | (32'h1 << 10), 0);
        rq(40'h1_0000_0000, 5, 1, 3, 0, 0);
        tag = "R5";
        rq(40'h1_0000_0000, 6, 1, 2, 1, 0);
        wr(0, 0, 32'h88 | (32'h1 << 23), 0);
        rq(40'h1_0000_0000, 6, 1, 2, 1, 0);
        rq(40'h1_0000_0000, 6, 0, 2, 1, 0);
        rq(40'h1_0000_0000, 6, 1, 2, 0, 0);

        // window 1: untranslated-only, nobody allowed
        tag = "R6";
        wr(1, 2, 32'h2, 0); wr(1, 3, 32'h1, 0); wr(1, 0, 32'h4, 0);
        rq(40'h2_0000_0000, 5, 0, 0, 0, 0);
        rq(40'h2_0000_0000, 5, 0, 0, 0, 1);

        // window 2 overlaps the upper granule of window 0, permits client 40
        tag = "R7";
        wr(2, 2, 32'h1, 0); wr(2, 1, 32'h0002_0000, 0); wr(2, 3, 32'h1, 0);
        wr(2, 5, 32'h100, 0); wr(2, 0, 32'h88, 0);
        rq(40'h1_0002_0000, 5, 0, 0, 0, 0);
        rq(40'h1_0000_0000, 5, 0, 0, 0, 0);
        rq(40'h1_0002_0000, 40, 0, 0, 0, 0);
        wr(0, 5, 32'h100, 0);
        rq(40'h1_0002_0000, 40, 0, 0, 0, 0);

        // window 3 frozen for all; window 4 frozen but secure-rewritable
        tag = "R8";
        wr(3, 2, 32'h3, 0); wr(3, 3, 32'h1, 0); wr(3, 0, 32'h2, 0);
        rq(40'h3_0000_0000, 5, 0, 0, 0, 0);
        wr(3, 3, 32'h0, 0);
        wr(3, 3, 32'h0, 1);
        wr(3, 0, 32'h0, 1);
        rq(40'h3_0000_0000, 5, 0, 0, 0, 0);
        wr(4, 2, 32'h4, 0); wr(4, 3, 32'h1, 0); wr(4, 0, 32'h3, 0);
        rq(40'h4_0000_0000, 5, 0, 0, 0, 0);
        wr(4, 3, 32'h0, 0);
        rq(40'h4_0000_0000, 5, 0, 0, 0, 0);
        wr(4, 3, 32'h0, 1);
        rq(40'h4_0000_0000, 5, 0, 0, 0, 0);

        // window 8: secure bypass both directions, no clients
        tag = "R5";
        wr(8, 2, 32'h5, 0); wr(8, 3, 32'h4, 0); wr(8, 0, 32'h0180_0000, 0);
        rq(40'h5_0001_0000, 200, 0, 0, 1, 0);
        rq(40'h5_0001_0000, 200, 1, 3, 1, 0);
        rq(40'h5_0001_0000, 5, 0, 0, 0, 0);

        // mixed random traffic
        tag = "R7";
        for (int i = 0; i < 600; i++) begin
            bit [39:0] bases [5] = '{40'h1_0000_0000, 40'h1_0002_0000, 40'h2_0000_0000,
                                     40'h4_0000_0000, 40'h5_0000_0000};
            int clients [4] = '{5, 6, 40, 200};
            err_clear = ($urandom_range(0, 15) == 0);
            rq(bases[$urandom_range(0, 4)] + 40'($urandom_range(0, 32'h9_0000)),
               clients[$urandom_range(0, 3)], 1'($urandom), $urandom_range(0, 3),
               1'($urandom), 1'($urandom));
            err_clear = 0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule